// File: doc/BRIEF.md
# Set-Clear-Toggle Aliased Register Bank

A bank of 32-bit control and status registers on a simple word-access bus. The byte address space is split in two halves by its top address bit. The lower half is a plain window: each word is one register with a fixed read-only mask. The upper half is an aliased window, where each register occupies four consecutive word slots. The first slot is the register itself. The other three slots are aliases. A write to an alias sets, clears or inverts only the bits the mask leaves writable.

Reset loads a per-register constant into every register. Registers in the aliased window that model PLL controls also get their lock flag (bit 31) forced high on top of that constant. Bit 31 is read-only in every aliased register, so the lock flag stays high. Every request is accepted in the cycle it is presented; there is no back-pressure. The block answers with a one-cycle `rsp_ready` pulse, together with read data and an error flag, in the following cycle.

Top module: `scta_regbank`

## Requirements
- R1: After reset, plain register k reads 32'hA5A5_0000 | k. Aliased register g reads (32'h1000 << g) | g. For g < PLL_GROUPS the aliased value also has bit 31 set.
- R2: Plain register k (k >= 2) has mask 32'hFFFF_0000 >> (4*((k-2)%5)). A write to a register's own slot keeps the bits where the mask is 1 and takes the write data where the mask is 0.
- R3: Plain register 0 has an all-ones mask and ignores every write. Plain register 1 has an all-zero mask and takes the full write data.
- R4: Slot offset 1 of an aliased group is the SET alias. A write there ORs (wdata & ~mask) into the register.
- R5: Slot offset 2 is the CLR alias. A write there clears the bits in (wdata & ~mask).
- R6: Slot offset 3 is the TOG alias. A write there XORs (wdata & ~mask) into the register. Aliased register g has mask 32'h8000_0000 | (32'hFF00_0000 >> (4*(g%6))).
- R7: A read of any of the three alias slots returns the current value of the group's register.
- R8: Slot offset 0 of aliased group g (word index 4g of the upper half) is the register itself. A write there uses the masked-merge rule of R2.
- R9: A misaligned address, or a word index at or above PLAIN_WORDS in the lower half, or at or above 4*GROUPS in the upper half, is an error. It leaves every register unchanged, returns read data 0 and raises `rsp_err` with the response.
- R10: `rsp_ready` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise.
- R11: Read data is the register value before the access. A write response carries read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, always accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; top bit selects the aliased half |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| rsp_err | output | 1 | Decode error, valid with rsp_ready |

## Verification
The bench builds the block with six plain registers and four aliased groups, two of which are PLL controls. With these values every register can be swept. The fully read-only and fully writable plain cases both occur. A locked group can be compared with an unlocked one. The first index past each half is one word away, which makes both range errors reachable.

// File: rtl/scta_pkg.sv
package scta_pkg;
  localparam int DW = 32;
  localparam int LOCK_BIT = 31;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } scta_op_e;

  function automatic logic [DW-1:0] plain_mask(int k);
    if (k == 0) return '1;
    if (k == 1) return '0;
    return 32'hFFFF_0000 >> (4 * ((k - 2) % 5));
  endfunction

  function automatic logic [DW-1:0] plain_rstv(int k);
    return 32'hA5A5_0000 | DW'(k);
  endfunction

  function automatic logic [DW-1:0] grp_mask(int g);
    return 32'h8000_0000 | (32'hFF00_0000 >> (4 * (g % 6)));
  endfunction

  function automatic logic [DW-1:0] grp_rstv(int g, int pll_groups);
    logic [DW-1:0] v;
    v = (32'h0000_1000 << (g % 16)) | DW'(g);
    if (g < pll_groups) v[LOCK_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/scta_decode.sv
module scta_decode
  import scta_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PLAIN_WORDS = 6,
  parameter int GROUPS      = 4,
  localparam int IDX_W  = ADDR_W - 3,
  localparam int PIDX_W = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1,
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              plain_hit,
  output logic [PIDX_W-1:0] plain_idx,
  output logic              alias_hit,
  output logic [GIDX_W-1:0] grp_idx,
  output scta_op_e          op
);
  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             upper;

  assign aligned = (addr[1:0] == 2'b00);
  assign upper   = addr[ADDR_W-1];
  assign idx     = addr[ADDR_W-2:2];

  assign plain_hit = aligned && !upper && (int'(idx) < PLAIN_WORDS);
  assign alias_hit = aligned && upper && (int'(idx) < 4 * GROUPS);
  assign plain_idx = idx[PIDX_W-1:0];
  assign grp_idx   = idx[GIDX_W+1:2];
  assign op        = scta_op_e'(idx[1:0]);
endmodule

// File: rtl/scta_cell.sv
module scta_cell
  import scta_pkg::*;
#(
  parameter logic [31:0] MASK = 32'h0,
  parameter logic [31:0] RSTV = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  scta_op_e      op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] wbits;
  logic [DW-1:0] nxt;

  assign wbits = wdata & ~MASK;

  always_comb begin
    unique case (op)
      OP_SET:  nxt = q | wbits;
      OP_CLR:  nxt = q & ~wbits;
      OP_TOG:  nxt = q ^ wbits;
      default: nxt = (q & MASK) | wbits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RSTV;
    else if (wr_en) q <= nxt;
  end

  // read-only bits never move on any kind of write
  assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & MASK) == ($past(q) & MASK)));
  // register untouched when not the write target
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  assert_set_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((q & $past(q)) == $past(q)));
  assert_clr_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLR) |=> ((q | $past(q)) == $past(q)));
endmodule

// File: rtl/scta_regbank.sv
module scta_regbank
  import scta_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PLAIN_WORDS = 6,
  parameter int GROUPS      = 4,
  parameter int PLL_GROUPS  = 2,
  localparam int PIDX_W = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1,
  localparam int GIDX_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int NREG   = PLAIN_WORDS + GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err
);
  logic              plain_hit, alias_hit;
  logic [PIDX_W-1:0] plain_idx;
  logic [GIDX_W-1:0] grp_idx;
  scta_op_e          op;
  logic [DW-1:0]     plain_q [PLAIN_WORDS];
  logic [DW-1:0]     grp_q   [GROUPS];
  logic [NREG-1:0]   wr_vec;
  logic [DW-1:0]     rd_val;
  logic              wr_go;

  scta_decode #(
    .ADDR_W(ADDR_W), .PLAIN_WORDS(PLAIN_WORDS), .GROUPS(GROUPS)
  ) u_dec (
    .addr(req_addr), .plain_hit(plain_hit), .plain_idx(plain_idx),
    .alias_hit(alias_hit), .grp_idx(grp_idx), .op(op)
  );

  assign wr_go = req_valid && req_we;

  for (genvar k = 0; k < PLAIN_WORDS; k++) begin : g_plain
    assign wr_vec[k] = wr_go && plain_hit && (plain_idx == PIDX_W'(k));
    scta_cell #(.MASK(plain_mask(k)), .RSTV(plain_rstv(k))) u_cell (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_vec[k]), .op(OP_BASE),
      .wdata(req_wdata), .q(plain_q[k])
    );
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_alias
    assign wr_vec[PLAIN_WORDS+g] = wr_go && alias_hit && (grp_idx == GIDX_W'(g));
    scta_cell #(.MASK(grp_mask(g)), .RSTV(grp_rstv(g, PLL_GROUPS))) u_cell (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_vec[PLAIN_WORDS+g]), .op(op),
      .wdata(req_wdata), .q(grp_q[g])
    );
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < PLAIN_WORDS; k++)
      if (plain_hit && plain_idx == PIDX_W'(k)) rd_val = plain_q[k];
    for (int g = 0; g < GROUPS; g++)
      if (alias_hit && grp_idx == GIDX_W'(g)) rd_val = grp_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_ready <= req_valid;
      rsp_err   <= req_valid && !(plain_hit || alias_hit);
      rsp_rdata <= (req_valid && !req_we) ? rd_val : '0;
    end
  end

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  assert_err_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(plain_hit || alias_hit)) |-> (wr_vec == '0));
  assert_ready_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  assert_no_spurious_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  assert_err_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_ready && rsp_rdata == '0));
  assert_write_rsp_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> (rsp_rdata == '0));
endmodule

// File: tb/scta_regbank_bench.sv
module scta_regbank_bench;
  localparam int AW = 15;
  localparam int NP = 6;
  localparam int NG = 4;
  localparam int NPLL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready;
  logic [31:0] rsp_rdata;
  logic rsp_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit [31:0] m_plain [NP];
  bit [31:0] m_grp [NG];
  bit exp_ready = 0;
  bit exp_err = 0;
  bit [31:0] exp_data = 0;
  string exp_tag = "R10";

  always #10 clk = ~clk;

  scta_regbank #(.ADDR_W(AW), .PLAIN_WORDS(NP), .GROUPS(NG), .PLL_GROUPS(NPLL)) u_scta_regbank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  function automatic bit [31:0] pmask(int k);
    if (k == 0) return 32'hFFFF_FFFF;
    if (k == 1) return 32'h0;
    return 32'hFFFF_0000 >> (4 * ((k - 2) % 5));
  endfunction

  function automatic bit [31:0] gmask(int g);
    return 32'h8000_0000 | (32'hFF00_0000 >> (4 * (g % 6)));
  endfunction

  task automatic chk(string tag, string what, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: compare last response, then present the next request to model and DUT
  task automatic step(bit v, bit we, bit [AW-1:0] a, bit [31:0] d, string tag);
    int idx;
    bit hit;
    bit [31:0] cur;
    @(negedge clk);
    chk(exp_tag, "ready", 32'(rsp_ready), 32'(exp_ready));
    chk(exp_tag, "err", 32'(rsp_err), 32'(exp_err));
    chk(exp_tag, "rdata", rsp_rdata, exp_data);
    idx = int'(a[AW-2:2]);
    hit = 0;
    cur = 0;
    if (a[1:0] == 0 && !a[AW-1] && idx < NP) begin
      hit = 1;
      cur = m_plain[idx];
      if (v && we) m_plain[idx] = (cur & pmask(idx)) | (d & ~pmask(idx));
    end else if (a[1:0] == 0 && a[AW-1] && idx < 4 * NG) begin
      int g;
      bit [31:0] wb;
      g = idx / 4;
      hit = 1;
      cur = m_grp[g];
      wb = d & ~gmask(g);
      if (v && we) begin
        case (idx % 4)
          0: m_grp[g] = (cur & gmask(g)) | wb;
          1: m_grp[g] = cur | wb;
          2: m_grp[g] = cur & ~wb;
          default: m_grp[g] = cur ^ wb;
        endcase
      end
    end
    exp_ready = v;
    exp_err = v && !hit;
    exp_data = (v && !we && hit) ? cur : 32'h0;
    exp_tag = tag;
    req_valid = v;
    req_we = we;
    req_addr = a;
    req_wdata = d;
  endtask

  task automatic rd(bit [AW-1:0] a, string tag);
    step(1, 0, a, 0, tag);
  endtask

  task automatic wr(bit [AW-1:0] a, bit [31:0] d, string tag);
    step(1, 1, a, d, tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, tag);
  endtask

  function automatic bit [AW-1:0] ga(int g, int slot);
    return AW'(32'h4000 + 16 * g + 4 * slot);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NP; k++) m_plain[k] = 32'hA5A5_0000 | k;
    for (int g = 0; g < NG; g++)
      m_grp[g] = (32'h1000 << g) | g | ((g < NPLL) ? 32'h8000_0000 : 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R10");
    idle("R10");
    // R1: reset values of every register
    for (int k = 0; k < NP; k++) rd(AW'(4 * k), "R1");
    for (int g = 0; g < NG; g++) rd(ga(g, 0), "R1");
    // R7: alias slots read the base
    for (int s = 1; s < 4; s++) rd(ga(0, s), "R7");
    for (int s = 1; s < 4; s++) rd(ga(3, s), "R7");
    // R2: masked merge on plain registers
    wr(AW'(8), 32'hFFFF_FFFF, "R11");
    rd(AW'(8), "R2");
    wr(AW'(12), 32'h0, "R11");
    rd(AW'(12), "R2");
    wr(AW'(20), 32'h1234_5678, "R11");
    rd(AW'(20), "R2");
    // R3: read-only and fully writable extremes
    wr(AW'(0), 32'h0, "R11");
    rd(AW'(0), "R3");
    wr(AW'(4), 32'h1234_5678, "R11");
    rd(AW'(4), "R3");
    // R4 R5 R6 on groups
    wr(ga(1, 1), 32'h0000_00F0, "R11");
    rd(ga(1, 0), "R4");
    wr(ga(1, 2), 32'h0000_2001, "R11");
    rd(ga(1, 0), "R5");
    wr(ga(1, 3), 32'hFFFF_FFFF, "R11");
    rd(ga(1, 0), "R6");
    wr(ga(0, 2), 32'hFFFF_FFFF, "R11");
    rd(ga(0, 0), "R5");
    wr(ga(0, 3), 32'h8000_0000, "R11");
    rd(ga(0, 3), "R6");
    wr(ga(3, 1), 32'hFFFF_FFFF, "R11");
    rd(ga(3, 2), "R4");
    // R8: base slot masked write
    wr(ga(2, 0), 32'h0F0F_0F0F, "R11");
    rd(ga(2, 0), "R8");
    wr(ga(2, 0), 32'h0, "R11");
    rd(ga(2, 1), "R8");
    // R9: errors leave state untouched
    wr(AW'(32'h4001), 32'hFFFF_FFFF, "R9");
    rd(ga(0, 0), "R9");
    wr(AW'(4 * NP), 32'hFFFF_FFFF, "R9");
    rd(AW'(4 * NP), "R9");
    wr(ga(NG, 0), 32'hFFFF_FFFF, "R9");
    rd(ga(NG, 1), "R9");
    rd(AW'(6), "R9");
    for (int k = 0; k < NP; k++) rd(AW'(4 * k), "R9");
    for (int g = 0; g < NG; g++) rd(ga(g, 0), "R9");
    // R10: gaps between requests
    idle("R10");
    rd(AW'(4), "R10");
    idle("R10");
    idle("R10");
    // R11: back-to-back write then read of the same register
    wr(AW'(4), 32'hCAFE_F00D, "R11");
    rd(AW'(4), "R11");
    wr(ga(3, 3), 32'h0000_FFFF, "R11");
    rd(ga(3, 0), "R11");
    idle("R10");
    idle("R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule